// File: doc/BRIEF.md
# Single-Channel TDM Slot Port with Bypass

This block is the serial side of one voice channel on a time-division-multiplexed line. A frame sync pulse, synchronous with the bit clock, marks where each frame begins. A bit counter numbers every bit period from that point on. During one programmed input slot the port shifts serial data in on falling clock edges. During one programmed output slot it drives serial data out on rising clock edges and asserts an output enable. At all other times the enable is low, which stands for a tri-stated line pin.

Three configuration bits choose how the channel behaves. The power-down bit silences the channel. The bypass bit loops the captured word back out unchanged. The coding-direction bit sets how wide each slot is. When neither power-down nor bypass is set, the captured word is handed to an external coding engine over a parallel strobe-and-data path. The engine's parallel result is then serialised in the output slot. The coding itself is outside this block.

Top module: `tdm_slot_port`

## Requirements
- R1: While reset is high, and after reset until the first frame sync, `sdout_en` and `eng_wvalid` are 0.
- R2: The rising edge at which `fsync` is sampled high starts bit position 0. Later edges count up by one. Slot index n covers bit positions 8n to 8n+7, and a narrow slot uses the first 4 of them.
- R3: `sdin` is sampled on the falling clock edge, only at bit positions inside the input window, most significant bit first. Values on `sdin` outside the window have no effect on the captured word.
- R4: The input window is 8 bits wide when `cfg_cmp`=1 and 4 bits wide when `cfg_cmp`=0. A 4-bit capture is right-aligned with the upper bits zero.
- R5: With `cfg_byp`=1 and `cfg_pd`=0, the word captured in one frame is driven in the output slot of the next frame. The output width equals the input width, the word goes out most significant bit first, and no handoff strobe is produced.
- R6: With `cfg_byp`=0 and `cfg_pd`=0, `eng_wvalid` is high for exactly one clock, in the cycle after the last input bit. `eng_wdata` then holds the captured word.
- R7: In coding mode, `eng_rdata` is sampled at the frame-sync edge. It is driven in that frame's output slot, 4 bits wide (`eng_rdata[3:0]`) when `cfg_cmp`=1 and 8 bits wide when `cfg_cmp`=0.
- R8: `sdout_en` is high exactly at the bit positions of the output window and changes on rising edges. `sdout` is 0 whenever `sdout_en` is 0.
- R9: With `cfg_pd`=1, `sdout_en` stays 0 and `eng_wvalid` stays 0.
- R10: Frames of 32 to 512 bit periods are supported. Any slot whose bits fall inside the frame works, including slot 0 and the last slot of a 512-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the serial line |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, sampled on the rising edge |
| sdin | input | 1 | Serial line input |
| cfg_pd | input | 1 | Channel power-down: output silent, no handoff |
| cfg_byp | input | 1 | Bypass: loop captured word back out |
| cfg_cmp | input | 1 | Coding direction: 1 compress, 0 expand |
| in_slot | input | 8 | Input slot index |
| out_slot | input | 8 | Output slot index |
| eng_rdata | input | 8 | Parallel result from the coding engine |
| sdout | output | 1 | Serial line output data |
| sdout_en | output | 1 | Output drive enable (low means high impedance) |
| eng_wvalid | output | 1 | One-cycle strobe: captured word ready |
| eng_wdata | output | 8 | Captured word handed to the engine |

## Verification
The bench places the output slot at bit 0. This catches a design that drives the previous frame's word, or drops a bit, at the frame-sync edge. It puts the input slot in the last byte of a 512-bit frame. This catches a counter that wraps early or a capture that misses the final falling edge. Nibble and byte widths are run in both bypass and coding modes. A design that picks the output width from the wrong bit sends too many or too few enabled bits. The bench drives both all-ones and all-zeros noise outside the input window, so a window that is off by one shows up as a corrupted capture.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  typedef enum logic [1:0] {
    CH_OFF    = 2'd0,
    CH_BYPASS = 2'd1,
    CH_CODE   = 2'd2
  } chan_mode_e;

  // Slot lane width: full unit when wide, half unit otherwise.
  function automatic int unsigned lane_width(input logic wide, input int unsigned full);
    return wide ? full : full / 2;
  endfunction

endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] pos_next
);

  localparam logic [PW-1:0] POS_MAX = '1;

  always_comb begin
    if (fsync)               pos_next = '0;
    else if (pos == POS_MAX) pos_next = pos;
    else                     pos_next = pos + 1'b1;
  end

  // Saturated value after reset lies beyond every slot window.
  always_ff @(posedge clk) begin
    if (rst) pos <= POS_MAX;
    else     pos <= pos_next;
  end

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int IDX_W     = 8,
  parameter int PW        = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 wide,
  input  logic [PW-1:0]        pos,
  input  logic [IDX_W-1:0]     slot_idx,
  input  logic                 sdin,
  output logic [SLOT_BITS-1:0] cap_val,
  output logic                 cap_pulse
);

  localparam int SH   = $clog2(SLOT_BITS);
  localparam int HALF = SLOT_BITS / 2;
  localparam logic [SLOT_BITS-1:0] LOW_MASK = {{(SLOT_BITS-HALF){1'b0}}, {HALF{1'b1}}};

  logic [PW-1:0]        base, off, wid;
  logic                 hit;
  logic [SLOT_BITS-1:0] shreg, assembled;

  assign base      = PW'(slot_idx) << SH;
  assign off       = pos - base;
  assign wid       = PW'(lane_width(wide, SLOT_BITS));
  assign hit       = (pos >= base) && (off < wid);
  assign assembled = {shreg[SLOT_BITS-2:0], sdin};

  // Capture on the falling edge, mid-bit.
  always_ff @(negedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cap_val   <= '0;
      cap_pulse <= 1'b0;
    end else begin
      cap_pulse <= 1'b0;
      if (enable && hit) begin
        shreg <= assembled;
        if (off == wid - 1'b1) begin
          cap_val   <= wide ? assembled : (assembled & LOW_MASK);
          cap_pulse <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int IDX_W     = 8,
  parameter int PW        = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fsync,
  input  logic                 enable,
  input  logic                 wide,
  input  logic [PW-1:0]        pos_next,
  input  logic [IDX_W-1:0]     slot_idx,
  input  logic [SLOT_BITS-1:0] load_val,
  output logic                 sdout,
  output logic                 sdout_en
);

  localparam int SH = $clog2(SLOT_BITS);

  logic [PW-1:0]        base, off, wid;
  logic [SH-1:0]        bsel;
  logic                 hit;
  logic [SLOT_BITS-1:0] hold, src;

  assign base = PW'(slot_idx) << SH;
  assign off  = pos_next - base;
  assign wid  = PW'(lane_width(wide, SLOT_BITS));
  assign hit  = (pos_next >= base) && (off < wid);
  assign bsel = SH'(wid - 1'b1 - off);
  // At the frame edge the freshly loaded word is already the source.
  assign src  = fsync ? load_val : hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      sdout    <= 1'b0;
      sdout_en <= 1'b0;
    end else begin
      if (fsync) hold <= load_val;
      sdout_en <= enable && hit;
      sdout    <= (enable && hit) ? src[bsel] : 1'b0;
    end
  end

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_slot_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int IDX_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fsync,
  input  logic                 sdin,
  input  logic                 cfg_pd,
  input  logic                 cfg_byp,
  input  logic                 cfg_cmp,
  input  logic [IDX_W-1:0]     in_slot,
  input  logic [IDX_W-1:0]     out_slot,
  input  logic [SLOT_BITS-1:0] eng_rdata,
  output logic                 sdout,
  output logic                 sdout_en,
  output logic                 eng_wvalid,
  output logic [SLOT_BITS-1:0] eng_wdata
);

  localparam int SH   = $clog2(SLOT_BITS);
  localparam int PW   = SH + IDX_W + 1;
  localparam int HALF = SLOT_BITS / 2;
  localparam logic [SLOT_BITS-1:0] LOW_MASK = {{(SLOT_BITS-HALF){1'b0}}, {HALF{1'b1}}};

  chan_mode_e           mode;
  logic [PW-1:0]        pos, pos_next;
  logic [SLOT_BITS-1:0] cap_val, load_val;
  logic                 cap_pulse, out_wide;

  always_comb begin
    if (cfg_pd)       mode = CH_OFF;
    else if (cfg_byp) mode = CH_BYPASS;
    else              mode = CH_CODE;
  end

  // Coding swaps widths: compress takes a byte, returns a nibble.
  assign out_wide = (mode == CH_BYPASS) ? cfg_cmp : !cfg_cmp;
  assign load_val = (mode == CH_BYPASS) ? cap_val
                  : (out_wide ? eng_rdata : (eng_rdata & LOW_MASK));

  tdm_bit_counter #(.PW(PW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .fsync    (fsync),
    .pos      (pos),
    .pos_next (pos_next)
  );

  tdm_slot_rx #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W), .PW(PW)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .enable    (mode != CH_OFF),
    .wide      (cfg_cmp),
    .pos       (pos),
    .slot_idx  (in_slot),
    .sdin      (sdin),
    .cap_val   (cap_val),
    .cap_pulse (cap_pulse)
  );

  tdm_slot_tx #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W), .PW(PW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .fsync    (fsync),
    .enable   (mode != CH_OFF),
    .wide     (out_wide),
    .pos_next (pos_next),
    .slot_idx (out_slot),
    .load_val (load_val),
    .sdout    (sdout),
    .sdout_en (sdout_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_wvalid <= 1'b0;
      eng_wdata  <= '0;
    end else begin
      eng_wvalid <= cap_pulse && (mode == CH_CODE);
      if (cap_pulse) eng_wdata <= cap_val;
    end
  end

endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk (
  input logic clk,
  input logic rst,
  input logic cfg_pd,
  input logic cfg_byp,
  input logic sdout,
  input logic sdout_en,
  input logic eng_wvalid
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sdout_en && !eng_wvalid));

  assert_pd_silent_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_pd |=> !sdout_en);

  assert_pd_no_handoff_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_pd |=> !eng_wvalid);

  assert_byp_no_handoff_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_byp |=> !eng_wvalid);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    eng_wvalid |=> !eng_wvalid);

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
    !sdout_en |-> !sdout);

endmodule

bind tdm_slot_port tdm_slot_port_chk u_chk (.*);

// File: tb/sim_tdm_slot_port.sv
module sim_tdm_slot_port;

  logic       clk = 1'b0;
  logic       rst, fsync, sdin, cfg_pd, cfg_byp, cfg_cmp;
  logic [7:0] in_slot, out_slot, eng_rdata, eng_wdata;
  logic       sdout, sdout_en, eng_wvalid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tdm_slot_port u0 (
    .clk(clk), .rst(rst), .fsync(fsync), .sdin(sdin),
    .cfg_pd(cfg_pd), .cfg_byp(cfg_byp), .cfg_cmp(cfg_cmp),
    .in_slot(in_slot), .out_slot(out_slot), .eng_rdata(eng_rdata),
    .sdout(sdout), .sdout_en(sdout_en),
    .eng_wvalid(eng_wvalid), .eng_wdata(eng_wdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One frame; entered right after the posedge whose fsync is already high.
  task automatic run_frame(input int len, input logic [7:0] din, input logic noise,
                           output logic [7:0] got, output int en_cnt, output int en_first,
                           output int wv_cnt, output logic [7:0] wdata, output int wv_pos);
    int iw   = cfg_cmp ? 8 : 4;
    int base = int'(in_slot) * 8;
    got = '0; en_cnt = 0; en_first = -1; wv_cnt = 0; wdata = '0; wv_pos = -1;
    for (int p = 0; p < len; p++) begin
      @(posedge clk);
      #2;
      fsync = (p == len - 1);
      if (sdout_en) begin
        if (en_cnt == 0) en_first = p;
        en_cnt++;
        got = {got[6:0], sdout};
      end
      if (eng_wvalid) begin
        wv_cnt++;
        wdata  = eng_wdata;
        wv_pos = p;
      end
      if (p >= base && p < base + iw) sdin = din[iw - 1 - (p - base)];
      else                            sdin = noise;
    end
  endtask

  task automatic set_cfg(input logic pd, input logic byp, input logic cmp,
                         input logic [7:0] islot, input logic [7:0] oslot);
    cfg_pd = pd; cfg_byp = byp; cfg_cmp = cmp; in_slot = islot; out_slot = oslot;
  endtask

  task automatic test_reset();
    rst = 1'b1; fsync = 1'b0; sdin = 1'b0; eng_rdata = 8'h00;
    set_cfg(1'b0, 1'b1, 1'b1, 8'd0, 8'd0);
    repeat (4) @(posedge clk);
    #2;
    check(!sdout_en && !eng_wvalid, "R1 outputs quiet in reset", {sdout_en, eng_wvalid}, 0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      #2;
      if (sdout_en || eng_wvalid) begin
        check(1'b0, "R1 quiet before first sync", {sdout_en, eng_wvalid}, 0);
        break;
      end
    end
    check(!sdout_en, "R1 no drive before sync", sdout_en, 0);
    fsync = 1'b1;
  endtask

  task automatic test_bypass_byte();
    logic [7:0] g, w; int n, f, wc, wp;
    set_cfg(1'b0, 1'b1, 1'b1, 8'd2, 8'd5);
    run_frame(64, 8'hA5, 1'b1, g, n, f, wc, w, wp);
    run_frame(64, 8'h3C, 1'b1, g, n, f, wc, w, wp);
    check(g == 8'hA5, "R5 bypass byte next frame", g, 8'hA5);
    check(n == 8, "R4 byte output width", n, 8);
    check(f == 40, "R2 output slot 5 start", f, 40);
    check(wc == 0, "R5 no handoff in bypass", wc, 0);
    run_frame(64, 8'h00, 1'b0, g, n, f, wc, w, wp);
    check(g == 8'h3C, "R3 noise outside window ignored", g, 8'h3C);
  endtask

  task automatic test_bypass_nibble();
    logic [7:0] g, w; int n, f, wc, wp;
    set_cfg(1'b0, 1'b1, 1'b0, 8'd1, 8'd3);
    run_frame(32, 8'h09, 1'b1, g, n, f, wc, w, wp);
    run_frame(32, 8'h06, 1'b0, g, n, f, wc, w, wp);
    check(g[3:0] == 4'h9, "R4 nibble bypass value", g[3:0], 4'h9);
    check(n == 4, "R4 nibble width", n, 4);
    check(f == 24, "R8 nibble window start", f, 24);
  endtask

  task automatic test_compress();
    logic [7:0] g, w; int n, f, wc, wp;
    eng_rdata = 8'hB7;
    set_cfg(1'b0, 1'b0, 1'b1, 8'd4, 8'd1);
    run_frame(64, 8'h11, 1'b1, g, n, f, wc, w, wp);
    run_frame(64, 8'hC3, 1'b1, g, n, f, wc, w, wp);
    check(wc == 1, "R6 one strobe per frame", wc, 1);
    check(w == 8'hC3, "R6 handoff byte", w, 8'hC3);
    check(wp == 40, "R6 strobe after last bit", wp, 40);
    check(g[3:0] == 4'h7 && n == 4, "R7 compress output nibble", {n[3:0], g[3:0]}, 8'h47);
    check(f == 8, "R8 compress output start", f, 8);
  endtask

  task automatic test_expand();
    logic [7:0] g, w; int n, f, wc, wp;
    eng_rdata = 8'h5E;
    set_cfg(1'b0, 1'b0, 1'b0, 8'd0, 8'd6);
    run_frame(64, 8'h02, 1'b1, g, n, f, wc, w, wp);
    run_frame(64, 8'h0D, 1'b1, g, n, f, wc, w, wp);
    check(w == 8'h0D && wc == 1, "R6 expand handoff nibble", w, 8'h0D);
    check(wp == 4, "R6 expand strobe position", wp, 4);
    check(g == 8'h5E && n == 8, "R7 expand output byte", g, 8'h5E);
    check(f == 48, "R8 expand output start", f, 48);
  endtask

  task automatic test_slot_zero();
    logic [7:0] g, w; int n, f, wc, wp;
    set_cfg(1'b0, 1'b1, 1'b1, 8'd3, 8'd0);
    run_frame(48, 8'h81, 1'b0, g, n, f, wc, w, wp);
    run_frame(48, 8'h7E, 1'b0, g, n, f, wc, w, wp);
    check(f == 0, "R10 output at bit 0", f, 0);
    check(g == 8'h81, "R10 slot 0 value", g, 8'h81);
  endtask

  task automatic test_long_frame();
    logic [7:0] g, w; int n, f, wc, wp;
    set_cfg(1'b0, 1'b1, 1'b1, 8'd63, 8'd62);
    run_frame(512, 8'h5A, 1'b0, g, n, f, wc, w, wp);
    run_frame(512, 8'hE1, 1'b1, g, n, f, wc, w, wp);
    check(g == 8'h5A, "R10 last slot of 512-bit frame", g, 8'h5A);
    check(f == 496, "R10 slot 62 start", f, 496);
  endtask

  task automatic test_power_down();
    logic [7:0] g, w; int n, f, wc, wp;
    eng_rdata = 8'hFF;
    set_cfg(1'b1, 1'b0, 1'b1, 8'd1, 8'd2);
    run_frame(64, 8'hAA, 1'b1, g, n, f, wc, w, wp);
    run_frame(64, 8'h55, 1'b1, g, n, f, wc, w, wp);
    check(n == 0, "R9 no output when powered down", n, 0);
    check(wc == 0, "R9 no handoff when powered down", wc, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_bypass_byte();
    test_bypass_nibble();
    test_compress();
    test_expand();
    test_slot_zero();
    test_long_frame();
    test_power_down();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule